// File: doc/BRIEF.md
# Sigma-Delta Decimator with Multiplexed Channel Sequencing

This block turns the one-bit output of a single sigma-delta modulator into corrected 12-bit samples for several sense inputs that share the modulator in turn. It owns the select lines of the analog input multiplexer. It also owns the order in which the inputs are visited, and it spends one fixed conversion slot on each input. The filter state is wiped at every slot boundary, so no charge from the previous input leaks into the next.

Each slot feeds the bitstream through a third-order CIC decimator with a ratio of 64 and lets it settle over three decimation periods. The first two partial outputs are dropped. At the end of the slot the filter output is scaled to 12 bits. An offset and a gain are then applied from live trim inputs, so the correction runs on every sample and needs no calibration mode. Power-stage switching edges are flagged on a blanking input. If that flag rises anywhere in a slot, the slot produces nothing and is repeated on the same input. Results appear with a channel tag and a single-cycle strobe.

Top module: `sd_decim_seq`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises, valid_o, result_o, chan_o and mux_sel_o are all zero.
- R2: A conversion takes exactly 192 accepted bits (bit_i sampled on clock edges where bit_en_i is 1). valid_o rises in the cycle after the edge that accepts the 192nd bit and never earlier.
- R3: For a bitstream that repeats with a period dividing 64 and holds k ones per 64 bits, the uncorrected value is min(64·k, 4095).
- R4: result_o = clamp(((raw − offset_i) · gain_i) >>> 11, 0, 4095), where raw is the uncorrected value, offset_i is an unsigned 12-bit code and gain_i is unsigned Q1.11 (2048 = unity).
- R5: A negative corrected value yields 0, and one above 4095 yields 4095.
- R6: Channels are visited in the order 0, 1, 2, 3, 0 … . mux_sel_o shows the channel being converted. It changes only on the cycle a result is published, and chan_o carries the channel the result was taken on.
- R7: If blank_i is 1 on any clock edge of a conversion, including one where no bit is accepted and the edge that accepts the final bit, that conversion publishes nothing. mux_sel_o stays on the same channel and the next conversion repeats it.
- R8: offset_i and gain_i are sampled only on the edge that accepts the final bit of a conversion. Earlier values during the slot have no effect.
- R9: valid_o is high for exactly one cycle per result.
- R10: The filter state is cleared at the end of every conversion, retried or not, so a result depends only on the bits of its own slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, a delayed copy of the modulator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Marks a cycle that carries a modulator bit |
| bit_i | input | 1 | Modulator output bit |
| blank_i | input | 1 | Driver switching window; spoils the current conversion |
| offset_i | input | 12 | Offset trim, unsigned code |
| gain_i | input | 12 | Gain trim, unsigned Q1.11 |
| mux_sel_o | output | 2 | Analog multiplexer select |
| result_o | output | 12 | Corrected sample |
| chan_o | output | 2 | Channel tag of result_o |
| valid_o | output | 1 | One-cycle strobe for a new result |

## Verification
A bad slot counter shifts the moment of valid_o against the 192nd accepted bit. It also makes the filter stop short of settling, so periodic patterns no longer give exact multiples of 64. Both effects are visible on the very first result after reset. A filter that is not cleared, or a blanking flag that is lost or left stuck, shows up in the next slot as a wrong value, a missing retry or a skipped channel on mux_sel_o, about 200 cycles after the fault. Trims that are sampled at the wrong time give a value that is computed from the decoy trims the bench drives before the final bit.

// File: rtl/sd_pkg.sv
`timescale 1ns/1ps
package sd_pkg;
  localparam int RES_W     = 12;
  localparam int GAIN_W    = 12;
  localparam int GAIN_FRAC = 11;
  localparam int RES_MAX   = (1 << RES_W) - 1;
endpackage

// File: rtl/sd_cic3.sv
`timescale 1ns/1ps
module sd_cic3 #(
  parameter int STAGES   = 3,
  parameter int DEC_LOG2 = 6,
  localparam int ACC_W   = STAGES * DEC_LOG2 + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bit_i,
  input  logic             dec_i,
  input  logic             clr_i,
  output logic [ACC_W-1:0] y_o
);
  logic [ACC_W-1:0] integ_q [STAGES];
  logic [ACC_W-1:0] integ_d [STAGES];
  logic [ACC_W-1:0] dly_q   [STAGES];
  logic [ACC_W-1:0] comb_in [STAGES];
  logic [ACC_W-1:0] comb    [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign integ_d[s] = integ_q[s] + {{(ACC_W-1){1'b0}}, bit_i};
      assign comb_in[s] = integ_d[STAGES-1];
    end else begin : g_next
      assign integ_d[s] = integ_q[s] + integ_d[s-1];
      assign comb_in[s] = comb[s-1];
    end
    assign comb[s] = comb_in[s] - dly_q[s];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        integ_q[s] <= '0;
        dly_q[s]   <= '0;
      end else if (en_i) begin
        if (clr_i) begin
          integ_q[s] <= '0;
          dly_q[s]   <= '0;
        end else begin
          integ_q[s] <= integ_d[s];
          if (dec_i) dly_q[s] <= comb_in[s];
        end
      end
    end
  end

  // combinational comb output: valid on the accepting edge of a decimation bit
  assign y_o = comb[STAGES-1];
endmodule

// File: rtl/sd_slot_seq.sv
`timescale 1ns/1ps
module sd_slot_seq #(
  parameter int NUM_CH   = 4,
  parameter int DEC_LOG2 = 6,
  parameter int CONV_LEN = 192,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int CNT_W   = $clog2(CONV_LEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bit_en_i,
  input  logic            blank_i,
  output logic            dec_o,
  output logic            clr_o,
  output logic            done_o,
  output logic [CH_W-1:0] ch_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             dirty_q;
  logic [CH_W-1:0]  ch_q;
  logic             last_w, end_w;

  assign last_w = (cnt_q == CNT_W'(CONV_LEN - 1));
  assign end_w  = bit_en_i && last_w;
  assign dec_o  = bit_en_i && (cnt_q[DEC_LOG2-1:0] == '1);
  assign clr_o  = end_w;
  assign done_o = end_w && !(dirty_q || blank_i);
  assign ch_o   = ch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      dirty_q <= 1'b0;
      ch_q    <= '0;
    end else begin
      if (bit_en_i) cnt_q <= last_w ? '0 : cnt_q + 1'b1;
      if (end_w)        dirty_q <= 1'b0;
      else if (blank_i) dirty_q <= 1'b1;
      if (done_o) ch_q <= (ch_q == CH_W'(NUM_CH - 1)) ? '0 : ch_q + 1'b1;
    end
  end
endmodule

// File: rtl/sd_trim.sv
`timescale 1ns/1ps
module sd_trim
  import sd_pkg::*;
#(
  parameter int ACC_W  = 19,
  parameter int RAW_SH = 6,
  parameter int CH_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [ACC_W-1:0]  y_i,
  input  logic [RES_W-1:0]  offset_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [RES_W-1:0]  result_o,
  output logic [CH_W-1:0]   chan_o,
  output logic              valid_o
);
  localparam int PW = RES_W + GAIN_W + 2;

  logic [ACC_W-1:0]     raw_ext;
  logic [RES_W-1:0]     raw;
  logic signed [RES_W:0] diff;
  logic [PW-1:0]        prod_u;
  logic signed [PW-1:0] scaled;
  logic [RES_W-1:0]     sat;

  assign raw_ext = y_i >> RAW_SH;
  assign raw     = (raw_ext > ACC_W'(RES_MAX)) ? RES_W'(RES_MAX) : raw_ext[RES_W-1:0];
  assign diff    = $signed({1'b0, raw}) - $signed({1'b0, offset_i});
  // two's complement product in PW bits; low PW bits are exact
  assign prod_u  = {{(PW-RES_W-1){diff[RES_W]}}, diff} * {{(PW-GAIN_W){1'b0}}, gain_i};
  assign scaled  = $signed(prod_u) >>> GAIN_FRAC;

  always_comb begin
    if (scaled < 0)                          sat = '0;
    else if (scaled > $signed(PW'(RES_MAX))) sat = RES_W'(RES_MAX);
    else                                     sat = scaled[RES_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      chan_o   <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= done_i;
      if (done_i) begin
        result_o <= sat;
        chan_o   <= ch_i;
      end
    end
  end
endmodule

// File: rtl/sd_decim_seq.sv
`timescale 1ns/1ps
module sd_decim_seq
  import sd_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int STAGES   = 3,
  parameter int DEC_LOG2 = 6,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int CONV_LEN = STAGES * (1 << DEC_LOG2),
  localparam int ACC_W    = STAGES * DEC_LOG2 + 1,
  localparam int RAW_SH   = STAGES * DEC_LOG2 - RES_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              bit_i,
  input  logic              blank_i,
  input  logic [RES_W-1:0]  offset_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [CH_W-1:0]   mux_sel_o,
  output logic [RES_W-1:0]  result_o,
  output logic [CH_W-1:0]   chan_o,
  output logic              valid_o
);
  logic             dec_w, clr_w, done_w;
  logic [ACC_W-1:0] y_w;

  sd_slot_seq #(.NUM_CH(NUM_CH), .DEC_LOG2(DEC_LOG2), .CONV_LEN(CONV_LEN)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .blank_i(blank_i),
    .dec_o(dec_w), .clr_o(clr_w), .done_o(done_w), .ch_o(mux_sel_o)
  );

  sd_cic3 #(.STAGES(STAGES), .DEC_LOG2(DEC_LOG2)) u_cic (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(bit_en_i), .bit_i(bit_i),
    .dec_i(dec_w), .clr_i(clr_w), .y_o(y_w)
  );

  sd_trim #(.ACC_W(ACC_W), .RAW_SH(RAW_SH), .CH_W(CH_W)) u_trim (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done_w), .ch_i(mux_sel_o), .y_i(y_w),
    .offset_i(offset_i), .gain_i(gain_i),
    .result_o(result_o), .chan_o(chan_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/sd_decim_seq_chk.sv
`timescale 1ns/1ps
module sd_decim_seq_chk #(
  parameter int NUM_CH   = 4,
  parameter int CONV_LEN = 192,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            bit_en_i,
  input logic            blank_i,
  input logic [CH_W-1:0] mux_sel_o,
  input logic [CH_W-1:0] chan_o,
  input logic            valid_o
);
  int unsigned nbits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      nbits_q <= 0;
    else if (valid_o) nbits_q <= bit_en_i ? 1 : 0;
    else              nbits_q <= nbits_q + (bit_en_i ? 1 : 0);
  end

  a_r2_whole_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (nbits_q != 0 && (nbits_q % CONV_LEN) == 0));

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r6_sel_moves_on_publish: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_sel_o != $past(mux_sel_o)) |-> valid_o);

  a_r6_tag_matches_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> chan_o == $past(mux_sel_o));

  a_r6_round_robin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> mux_sel_o == ((chan_o == CH_W'(NUM_CH - 1)) ? '0 : chan_o + 1'b1));

  a_r7_blank_kills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |=> !valid_o);
endmodule

bind sd_decim_seq sd_decim_seq_chk #(.NUM_CH(NUM_CH), .CONV_LEN(CONV_LEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .blank_i(blank_i),
  .mux_sel_o(mux_sel_o), .chan_o(chan_o), .valid_o(valid_o)
);

// File: tb/sd_decim_seq_test.sv
`timescale 1ns/1ps
module sd_decim_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_en = 1'b0, bit_v = 1'b0, blank = 1'b0;
  logic [11:0] offset = '0, gain = '0;
  logic [1:0]  mux_sel, chan;
  logic [11:0] result;
  logic        valid;
  int checks = 0, failures = 0, cur_ch = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sd_decim_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .bit_i(bit_v), .blank_i(blank),
    .offset_i(offset), .gain_i(gain), .mux_sel_o(mux_sel), .result_o(result),
    .chan_o(chan), .valid_o(valid)
  );

  function automatic int exp_val(int per, int ones, int off, int g);
    int raw, d, p;
    raw = ones * (64 / per) * 64;
    if (raw > 4095) raw = 4095;
    d = raw - off;
    p = (d * g) >>> 11;
    if (p < 0) p = 0;
    if (p > 4095) p = 4095;
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bmode: 0 clean, 1 blank on bit strobe bidx, 2 blank on idle edge before bidx
  task automatic conv(input int per, input int ones, input int bmode, input int bidx,
                      input int off, input int g);
    bit early = 0;
    int v, r, c, m;
    for (int i = 0; i < 192; i++) begin
      int gap = $urandom % 3;
      if (bmode == 2 && i == bidx && gap == 0) gap = 1;
      for (int j = 0; j < gap; j++) begin
        @(negedge clk);
        if (valid) early = 1;
        bit_en = 0;
        blank  = (bmode == 2 && i == bidx && j == 0);
      end
      @(negedge clk);
      if (valid) early = 1;
      bit_en = 1;
      bit_v  = ((i % per) < ones);
      blank  = (bmode == 1 && i == bidx);
      if (i == 0)   begin offset = 12'($urandom); gain = 12'($urandom); end // decoys (R8)
      if (i == 191) begin offset = 12'(off); gain = 12'(g); end
    end
    @(negedge clk);
    bit_en = 0; blank = 0;
    v = valid; r = result; c = chan; m = mux_sel;
    chk(!early, "R2 early valid", early, 0);
    if (bmode == 0) begin
      chk(v == 1, "R2 valid after 192 bits", v, 1);
      chk(r == exp_val(per, ones, off, g), "R3/R4/R5/R8/R10 result", r, exp_val(per, ones, off, g));
      chk(c == cur_ch, "R6 chan tag", c, cur_ch);
      cur_ch = (cur_ch + 1) % 4;
      chk(m == cur_ch, "R6 mux advance", m, cur_ch);
    end else begin
      chk(v == 0, "R7 blanked no valid", v, 0);
      chk(m == cur_ch, "R7 mux held for retry", m, cur_ch);
    end
    @(negedge clk);
    chk(valid == 0, "R9 one-cycle valid", valid, 0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #35;
    chk(valid == 0 && result == 0 && chan == 0 && mux_sel == 0, "R1 reset held", {valid, result}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(valid == 0 && result == 0 && chan == 0 && mux_sel == 0, "R1 after release", {valid, result}, 0);

    conv(1, 1, 0, 0, 0, 2048);      // all ones -> 4095 (R3, R5 high)
    conv(1, 0, 0, 0, 0, 2048);      // all zeros -> 0
    conv(2, 1, 0, 0, 0, 2048);      // half -> 2048
    conv(4, 1, 0, 0, 2000, 2048);   // 1024 - 2000 -> 0 (R5 low)
    conv(64, 48, 0, 0, 0, 4000);    // 3072*4000/2048 -> clamp 4095
    conv(8, 6, 0, 0, 100, 1024);    // (3072-100)/2 = 1486 (R4)
    conv(16, 3, 0, 0, 0, 2048);     // R10: low density after high
    // blanking corners (R7) each followed by a clean retry on the same channel
    conv(2, 1, 2, 100, 0, 2048);
    conv(2, 1, 0, 0, 0, 2048);
    conv(1, 1, 1, 0, 0, 2048);
    conv(32, 5, 1, 191, 0, 2048);
    conv(32, 5, 0, 0, 0, 2048);
    conv(4, 3, 2, 0, 50, 3000);
    conv(4, 3, 0, 0, 50, 3000);

    for (int n = 0; n < 30; n++) begin
      int per = 1 << ($urandom % 7);
      int ones = $urandom % (per + 1);
      int off = ($urandom % 2) ? $urandom % 1024 : 0;
      int g = $urandom % 4096;
      if ($urandom % 4 == 0) conv(per, ones, 1 + ($urandom % 2), $urandom % 192, off, g);
      conv(per, ones, 0, 0, off, g);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule